// File: doc/BRIEF.md
# Serial Register Port for a Timekeeping Peripheral

This block lets a host processor reach the byte registers of a real-time-clock peripheral over a four-wire serial bus. The host raises chip select and sends an address byte. The top bit of that byte chooses the direction: 1 for write, 0 for read. The low seven bits give the first address. Every byte that follows is written to, or read from, the current address, and the address then steps by one. A single transaction can therefore move the whole date/time group, both alarm groups, or the three configuration bytes.

The address space holds 15 time and alarm bytes, a control byte, a status byte holding two alarm flags, a charger-configuration byte, and 96 bytes of general storage. The time, alarm and storage bytes share one dual-port array. Its second read port feeds the external counting and alarm-compare logic. The control, status and charger bytes sit in flops, so they can drive their own output ports. A write-protect bit in the control byte blocks every write except a control write that clears the protection.

The serial pins are oversampled by the system clock. The serial clock must stay in each level for at least eight system clocks.

Top module: `tkp_spi_regfile`

## Requirements
- R1: Bytes are 8 bits and travel MSB first. SCLK idles low. MOSI is taken at each SCLK falling edge, and MISO changes after each rising edge. The first byte of a transaction is the address byte: bit 7 = 1 means write, bit 7 = 0 means read, and bits 6:0 give the start address.
- R2: Chip select is active high. While it is low, `spi_miso_oe` is 0. Dropping it abandons any partial byte, and the next transaction again begins with an address byte.
- R3: After each data byte the address increases by one. It wraps from 0x7F to 0x00.
- R4: Addresses 0x00–0x0E (time and alarm bytes) and 0x20–0x7F (storage) read back the last value written.
- R5: The control byte is at 0x0F. Its bits 5:3 always read 0. Its stored value appears on `ctrl_q`.
- R6: The status byte is at 0x10, and bits 7:2 read 0. Flag bit i becomes 1 on any clock with `alarm_set[i]` high. A host write clears each flag whose written bit is 0 and keeps each flag whose written bit is 1. When `alarm_set[i]` and a clearing write fall in the same clock, the flag ends set.
- R7: The charger-configuration byte is at 0x11. It holds all 8 bits and appears on `trickle_q`.
- R8: Addresses 0x12–0x1F read 0x00, and writes to them change nothing.
- R9: Control bit 6 is write protect. While it is 1, writes to every address other than 0x0F are ignored. A write to 0x0F is accepted only if its bit 6 is 0. Later bytes of the same burst see the new protection state.
- R10: `tk_rdata` shows the stored byte at `tk_addr` one clock later.
- R11: After `rst`: `ctrl_q` = 0x40, the flags are 0, `trickle_q` = 0x00, and `spi_miso_oe` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_sclk | input | 1 | Serial clock from the host |
| spi_cs | input | 1 | Chip select, active high |
| spi_mosi | input | 1 | Serial data in |
| spi_miso | output | 1 | Serial data out |
| spi_miso_oe | output | 1 | Drive enable for MISO; 0 means high impedance |
| alarm_set | input | 2 | Alarm-match pulses that set the status flags |
| tk_addr | input | 7 | Read address from the timekeeping logic |
| tk_rdata | output | 8 | Stored byte at `tk_addr`, one clock later |
| ctrl_q | output | 8 | Current control byte |
| alarm_flag | output | 2 | Current status flags |
| trickle_q | output | 8 | Current charger-configuration byte |

## Verification
Two functions can act on the status byte in the same clock: the alarm logic setting a flag, and the host writing 0 to clear it. The bench provokes this by pulsing `alarm_set` for a single clock at several fixed offsets around the last SCLK falling edge of a status write. It predicts the outcome for each offset:
- Before the write's cycle, the flag is set and then cleared.
- In the write's own cycle, the flag stays set.
- After the write's cycle, the flag is set again.

The bench judges each trial by the `alarm_flag` value it reads afterwards. Only the set-wins ordering passes all offsets.

// File: rtl/tkp_pkg.sv
package tkp_pkg;

  typedef enum logic [2:0] {
    RG_STORE,
    RG_CTRL,
    RG_STAT,
    RG_TRKL,
    RG_NONE
  } region_e;

  localparam logic [7:0] CTRL_KEEP = 8'hC7;
  localparam int         WP_POS    = 6;

endpackage

// File: rtl/tkp_spi_sync.sv
module tkp_spi_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic sclk_in,
  input  logic cs_in,
  input  logic mosi_in,
  output logic cs_act,
  output logic mosi_s,
  output logic sclk_rise,
  output logic sclk_fall
);

  logic [SYNC_STAGES:0]   sclk_p;
  logic [SYNC_STAGES-1:0] cs_p;
  logic [SYNC_STAGES-1:0] mosi_p;
  logic                   sclk_s;
  logic                   sclk_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_p <= '0;
      cs_p   <= '0;
      mosi_p <= '0;
    end else begin
      sclk_p <= {sclk_p[SYNC_STAGES-1:0], sclk_in};
      cs_p   <= {cs_p[SYNC_STAGES-2:0], cs_in};
      mosi_p <= {mosi_p[SYNC_STAGES-2:0], mosi_in};
    end
  end

  assign sclk_s    = sclk_p[SYNC_STAGES-1];
  assign sclk_d    = sclk_p[SYNC_STAGES];
  assign cs_act    = cs_p[SYNC_STAGES-1];
  assign mosi_s    = mosi_p[SYNC_STAGES-1];
  assign sclk_rise = cs_act & sclk_s & ~sclk_d;
  assign sclk_fall = cs_act & ~sclk_s & sclk_d;

  AST_EDGE_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(sclk_rise && sclk_fall)); // R1

endmodule

// File: rtl/tkp_spi_shifter.sv
module tkp_spi_shifter #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cs_act,
  input  logic          sclk_rise,
  input  logic          sclk_fall,
  input  logic          mosi_s,
  input  logic          load,
  input  logic [DW-1:0] load_byte,
  output logic          rx_valid,
  output logic [DW-1:0] rx_byte,
  output logic          miso_q,
  output logic          miso_oe
);

  localparam int CNT_W = $clog2(DW);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DW - 1);

  logic [CNT_W-1:0] bit_cnt;
  logic [DW-1:0]    sh_in;
  logic [DW-1:0]    tx_sh;

  always_ff @(posedge clk) begin
    if (rst || !cs_act) begin
      bit_cnt  <= '0;
      sh_in    <= '0;
      rx_valid <= 1'b0;
      rx_byte  <= '0;
      tx_sh    <= '0;
      miso_q   <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      if (sclk_fall) begin
        sh_in <= {sh_in[DW-2:0], mosi_s};
        if (bit_cnt == LAST_BIT) begin
          bit_cnt  <= '0;
          rx_valid <= 1'b1;
          rx_byte  <= {sh_in[DW-2:0], mosi_s};
        end else begin
          bit_cnt <= bit_cnt + 1'b1;
        end
      end
      if (load && sclk_rise) begin
        miso_q <= load_byte[DW-1];
        tx_sh  <= {load_byte[DW-2:0], 1'b0};
      end else if (load) begin
        tx_sh <= load_byte;
      end else if (sclk_rise) begin
        miso_q <= tx_sh[DW-1];
        tx_sh  <= {tx_sh[DW-2:0], 1'b0};
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) miso_oe <= 1'b0;
    else     miso_oe <= cs_act;
  end

  AST_IDLE_CLEAR: assert property (@(posedge clk) disable iff (rst)
    !cs_act |=> (bit_cnt == '0) && !rx_valid); // R2
  AST_BYTE_FRAME: assert property (@(posedge clk) disable iff (rst)
    rx_valid |-> $past(sclk_fall)); // R1

endmodule

// File: rtl/tkp_byte_ram.sv
module tkp_byte_ram #(
  parameter int AW = 7,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          a_we,
  input  logic [AW-1:0] a_addr,
  input  logic [DW-1:0] a_wdata,
  output logic [DW-1:0] a_rdata,
  input  logic [AW-1:0] b_addr,
  output logic [DW-1:0] b_rdata
);

  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (a_we) mem[a_addr] <= a_wdata;
    a_rdata <= mem[a_addr];
  end

  always_ff @(posedge clk) begin
    b_rdata <= mem[b_addr];
  end

endmodule

// File: rtl/tkp_reg_ctl.sv
module tkp_reg_ctl
  import tkp_pkg::*;
#(
  parameter int              AW         = 7,
  parameter int              DW         = 8,
  parameter int              NUM_ALARMS = 2,
  parameter logic [AW-1:0]   CTRL_ADR   = 7'h0F,
  parameter logic [AW-1:0]   RAM_BASE   = 7'h20,
  parameter logic [DW-1:0]   CTRL_RST   = 8'h40,
  parameter logic [DW-1:0]   TRKL_RST   = 8'h00
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  cs_act,
  input  logic                  rx_valid,
  input  logic [DW-1:0]         rx_byte,
  input  logic [NUM_ALARMS-1:0] alarm_set,
  output logic                  ram_we,
  output logic [AW-1:0]         ram_addr,
  output logic [DW-1:0]         ram_wdata,
  input  logic [DW-1:0]         ram_rdata,
  output logic                  load,
  output logic [DW-1:0]         load_byte,
  output logic [DW-1:0]         ctrl_q,
  output logic [NUM_ALARMS-1:0] stat_q,
  output logic [DW-1:0]         trkl_q
);

  localparam logic [AW-1:0] STAT_ADR = CTRL_ADR + 1'b1;
  localparam logic [AW-1:0] TRKL_ADR = CTRL_ADR + 2'd2;

  logic          first_q;
  logic          wr_q;
  logic [AW-1:0] addr_q;
  logic          rd_pend_q;
  region_e       rd_region_q;
  logic [DW-1:0] reg_rd_q;

  logic          data_byte;
  logic          wr_fire;
  logic          rd_fire;
  logic          wp_on;
  logic          accept;
  logic [AW-1:0] rd_addr;
  region_e       wr_region;
  region_e       rd_region;

  function automatic region_e region_of(input logic [AW-1:0] a);
    region_e r;
    if (a < CTRL_ADR || a >= RAM_BASE) r = RG_STORE;
    else if (a == CTRL_ADR)            r = RG_CTRL;
    else if (a == STAT_ADR)            r = RG_STAT;
    else if (a == TRKL_ADR)            r = RG_TRKL;
    else                               r = RG_NONE;
    return r;
  endfunction

  assign data_byte = rx_valid & ~first_q;
  assign wr_fire   = data_byte & wr_q;
  assign rd_fire   = rx_valid & (first_q ? ~rx_byte[DW-1] : ~wr_q);
  assign wp_on     = ctrl_q[WP_POS];
  assign wr_region = region_of(addr_q);
  assign rd_addr   = first_q ? rx_byte[AW-1:0] : addr_q + 1'b1;
  assign rd_region = region_of(rd_addr);
  assign accept    = wr_fire &
                     (~wp_on | ((wr_region == RG_CTRL) & ~rx_byte[WP_POS]));

  assign ram_we    = accept & (wr_region == RG_STORE);
  assign ram_addr  = ram_we ? addr_q : rd_addr;
  assign ram_wdata = rx_byte;

  // transaction sequencing, cleared while chip select is low
  always_ff @(posedge clk) begin
    if (rst || !cs_act) begin
      first_q     <= 1'b1;
      wr_q        <= 1'b0;
      addr_q      <= '0;
      rd_pend_q   <= 1'b0;
      rd_region_q <= RG_NONE;
      reg_rd_q    <= '0;
    end else begin
      rd_pend_q <= rd_fire;
      if (rx_valid) begin
        if (first_q) begin
          first_q <= 1'b0;
          wr_q    <= rx_byte[DW-1];
          addr_q  <= rx_byte[AW-1:0];
        end else begin
          addr_q  <= addr_q + 1'b1;
        end
      end
      if (rd_fire) begin
        rd_region_q <= rd_region;
        case (rd_region)
          RG_CTRL: reg_rd_q <= ctrl_q;
          RG_STAT: reg_rd_q <= {{(DW-NUM_ALARMS){1'b0}}, stat_q};
          RG_TRKL: reg_rd_q <= trkl_q;
          default: reg_rd_q <= '0;
        endcase
      end
    end
  end

  assign load      = rd_pend_q;
  assign load_byte = (rd_region_q == RG_STORE) ? ram_rdata : reg_rd_q;

  // flop-based registers, kept across transactions
  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= CTRL_RST & CTRL_KEEP;
      stat_q <= '0;
      trkl_q <= TRKL_RST;
    end else begin
      if (accept && wr_region == RG_CTRL) ctrl_q <= rx_byte & CTRL_KEEP;
      if (accept && wr_region == RG_TRKL) trkl_q <= rx_byte;
      if (accept && wr_region == RG_STAT)
        stat_q <= (stat_q & rx_byte[NUM_ALARMS-1:0]) | alarm_set;
      else
        stat_q <= stat_q | alarm_set;
    end
  end

  AST_WP_GUARD: assert property (@(posedge clk) disable iff (rst)
    (wp_on && wr_fire && addr_q != CTRL_ADR) |-> !ram_we); // R9
  AST_WP_TRKL: assert property (@(posedge clk) disable iff (rst)
    (wp_on && wr_fire && addr_q == TRKL_ADR) |=> trkl_q == $past(trkl_q)); // R9
  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (rst)
    (cs_act && rx_valid && !first_q) |=> addr_q == $past(addr_q) + 1'b1); // R3
  AST_FLAG_SET: assert property (@(posedge clk) disable iff (rst)
    (|alarm_set) |=> ((stat_q & $past(alarm_set)) == $past(alarm_set))); // R6
  AST_ONE_PORT: assert property (@(posedge clk) disable iff (rst)
    $onehot0({ram_we, rd_fire})); // R4
  AST_IDLE_ADDR: assert property (@(posedge clk) disable iff (rst)
    !cs_act |=> first_q && !rd_pend_q); // R2

endmodule

// File: rtl/tkp_spi_regfile.sv
module tkp_spi_regfile
  import tkp_pkg::*;
#(
  parameter int            AW          = 7,
  parameter int            DW          = 8,
  parameter int            NUM_ALARMS  = 2,
  parameter int            SYNC_STAGES = 2,
  parameter logic [AW-1:0] CTRL_ADR    = 7'h0F,
  parameter logic [AW-1:0] RAM_BASE    = 7'h20,
  parameter logic [DW-1:0] CTRL_RST    = 8'h40,
  parameter logic [DW-1:0] TRKL_RST    = 8'h00
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  spi_sclk,
  input  logic                  spi_cs,
  input  logic                  spi_mosi,
  output logic                  spi_miso,
  output logic                  spi_miso_oe,
  input  logic [NUM_ALARMS-1:0] alarm_set,
  input  logic [AW-1:0]         tk_addr,
  output logic [DW-1:0]         tk_rdata,
  output logic [DW-1:0]         ctrl_q,
  output logic [NUM_ALARMS-1:0] alarm_flag,
  output logic [DW-1:0]         trickle_q
);

  logic          cs_act;
  logic          mosi_s;
  logic          sclk_rise;
  logic          sclk_fall;
  logic          rx_valid;
  logic [DW-1:0] rx_byte;
  logic          load;
  logic [DW-1:0] load_byte;
  logic          ram_we;
  logic [AW-1:0] ram_addr;
  logic [DW-1:0] ram_wdata;
  logic [DW-1:0] ram_rdata;

  tkp_spi_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst       (rst),
    .sclk_in   (spi_sclk),
    .cs_in     (spi_cs),
    .mosi_in   (spi_mosi),
    .cs_act    (cs_act),
    .mosi_s    (mosi_s),
    .sclk_rise (sclk_rise),
    .sclk_fall (sclk_fall)
  );

  tkp_spi_shifter #(.DW(DW)) u_shift (
    .clk       (clk),
    .rst       (rst),
    .cs_act    (cs_act),
    .sclk_rise (sclk_rise),
    .sclk_fall (sclk_fall),
    .mosi_s    (mosi_s),
    .load      (load),
    .load_byte (load_byte),
    .rx_valid  (rx_valid),
    .rx_byte   (rx_byte),
    .miso_q    (spi_miso),
    .miso_oe   (spi_miso_oe)
  );

  tkp_reg_ctl #(
    .AW(AW), .DW(DW), .NUM_ALARMS(NUM_ALARMS),
    .CTRL_ADR(CTRL_ADR), .RAM_BASE(RAM_BASE),
    .CTRL_RST(CTRL_RST), .TRKL_RST(TRKL_RST)
  ) u_ctl (
    .clk       (clk),
    .rst       (rst),
    .cs_act    (cs_act),
    .rx_valid  (rx_valid),
    .rx_byte   (rx_byte),
    .alarm_set (alarm_set),
    .ram_we    (ram_we),
    .ram_addr  (ram_addr),
    .ram_wdata (ram_wdata),
    .ram_rdata (ram_rdata),
    .load      (load),
    .load_byte (load_byte),
    .ctrl_q    (ctrl_q),
    .stat_q    (alarm_flag),
    .trkl_q    (trickle_q)
  );

  tkp_byte_ram #(.AW(AW), .DW(DW)) u_ram (
    .clk     (clk),
    .a_we    (ram_we),
    .a_addr  (ram_addr),
    .a_wdata (ram_wdata),
    .a_rdata (ram_rdata),
    .b_addr  (tk_addr),
    .b_rdata (tk_rdata)
  );

  AST_OE_IDLE: assert property (@(posedge clk) disable iff (rst)
    !cs_act |=> !spi_miso_oe); // R2

endmodule

// File: tb/tb_tkp_spi_regfile.sv
`timescale 1ns/1ps
module tb_tkp_spi_regfile;

  localparam int HALF = 8;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       spi_sclk = 1'b0;
  logic       spi_cs = 1'b0;
  logic       spi_mosi = 1'b0;
  logic       spi_miso;
  logic       spi_miso_oe;
  logic [1:0] alarm_set = 2'b00;
  logic [6:0] tk_addr = 7'h00;
  logic [7:0] tk_rdata;
  logic [7:0] ctrl_q;
  logic [1:0] alarm_flag;
  logic [7:0] trickle_q;

  tkp_spi_regfile dut (
    .clk(clk), .rst(rst), .spi_sclk(spi_sclk), .spi_cs(spi_cs),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso), .spi_miso_oe(spi_miso_oe),
    .alarm_set(alarm_set), .tk_addr(tk_addr), .tk_rdata(tk_rdata),
    .ctrl_q(ctrl_q), .alarm_flag(alarm_flag), .trickle_q(trickle_q)
  );

  always #2 clk = ~clk;

  int n_cmp = 0;
  int n_bad = 0;
  bit idle_chk = 1'b0;
  bit done = 1'b0;

  logic [7:0] m_mem [128];
  bit         m_val [128];
  logic [7:0] m_ctrl = 8'h40;
  logic [7:0] m_trkl = 8'h00;
  logic [1:0] m_flag = 2'b00;

  logic [7:0] tx_buf [16];
  logic [7:0] rx_buf [16];

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%02h expected=%02h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic string tag_of(input logic [6:0] a);
    if (a <= 7'h0E || a >= 7'h20) return "R4";
    if (a == 7'h0F) return "R5";
    if (a == 7'h10) return "R6";
    if (a == 7'h11) return "R7";
    return "R8";
  endfunction

  function automatic logic [7:0] m_read(input logic [6:0] a);
    if (a <= 7'h0E || a >= 7'h20) return m_mem[a];
    if (a == 7'h0F) return m_ctrl;
    if (a == 7'h10) return {6'b0, m_flag};
    if (a == 7'h11) return m_trkl;
    return 8'h00;
  endfunction

  function automatic void m_apply(input logic [6:0] a, input logic [7:0] b);
    if (m_ctrl[6] && !(a == 7'h0F && !b[6])) return;
    if (a <= 7'h0E || a >= 7'h20) begin
      m_mem[a] = b;
      m_val[a] = 1'b1;
    end else if (a == 7'h0F) m_ctrl = b & 8'hC7;
    else if (a == 7'h10) m_flag = m_flag & b[1:0];
    else if (a == 7'h11) m_trkl = b;
  endfunction

  // every-clock comparison of the quiet outputs against the model
  always @(posedge clk) begin
    #1;
    if (idle_chk && !rst && !done) begin
      chk("R5", ctrl_q, m_ctrl);
      chk("R7", trickle_q, m_trkl);
      chk("R6", {6'b0, alarm_flag}, {6'b0, m_flag});
      chk("R2", {7'b0, spi_miso_oe}, 8'h00);
      if (m_val[tk_addr]) chk("R10", tk_rdata, m_mem[tk_addr]);
    end
  end

  task automatic spi_byte(input logic [7:0] tx, output logic [7:0] rx, input int race_k);
    for (int i = 7; i >= 0; i--) begin
      @(negedge clk);
      spi_sclk = 1'b1;
      spi_mosi = tx[i];
      repeat (HALF) @(negedge clk);
      rx[i] = spi_miso;
      spi_sclk = 1'b0;
      if (i == 0 && race_k > 0) begin
        repeat (race_k) @(negedge clk);
        alarm_set = 2'b01;
        @(negedge clk);
        alarm_set = 2'b00;
        repeat (HALF - race_k - 1) @(negedge clk);
      end else begin
        repeat (HALF - 1) @(negedge clk);
      end
    end
  endtask

  task automatic txn(input logic [7:0] abyte, input int n, input int race_k);
    logic [7:0] junk;
    idle_chk = 1'b0;
    @(negedge clk);
    spi_cs = 1'b1;
    repeat (8) @(negedge clk);
    spi_byte(abyte, junk, -1);
    chk("R2", {7'b0, spi_miso_oe}, 8'h01);
    for (int i = 0; i < n; i++)
      spi_byte(tx_buf[i], rx_buf[i], (i == n - 1) ? race_k : -1);
    repeat (HALF) @(negedge clk);
    spi_cs = 1'b0;
    repeat (8) @(negedge clk);
  endtask

  task automatic wr(input logic [6:0] a, input int n, input int race_k);
    txn({1'b1, a}, n, race_k);
    for (int i = 0; i < n; i++) m_apply(a + 7'(i), tx_buf[i]);
    idle_chk = 1'b1;
  endtask

  task automatic rd(input logic [6:0] a, input int n, input string tag);
    txn({1'b0, a}, n, -1);
    for (int i = 0; i < n; i++) begin
      logic [6:0] aa;
      aa = a + 7'(i);
      chk((tag == "") ? tag_of(aa) : tag, rx_buf[i], m_read(aa));
    end
    idle_chk = 1'b1;
  endtask

  task automatic pulse_alarm(input logic [1:0] v);
    @(negedge clk);
    alarm_set = v;
    m_flag = m_flag | v;
    @(negedge clk);
    alarm_set = 2'b00;
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 128; i++) begin
      m_mem[i] = 8'h00;
      m_val[i] = 1'b0;
    end
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11: state right after reset
    chk("R11", ctrl_q, 8'h40);
    chk("R11", trickle_q, 8'h00);
    chk("R11", {6'b0, alarm_flag}, 8'h00);
    chk("R11", {7'b0, spi_miso_oe}, 8'h00);
    idle_chk = 1'b1;

    // R1: read framing on the control byte
    rd(7'h0F, 1, "R1");

    // R9: writes blocked while protected
    tx_buf[0] = 8'hA5;
    wr(7'h11, 1, -1);
    rd(7'h11, 1, "R9");
    tx_buf[0] = 8'h7F;
    wr(7'h0F, 1, -1);
    rd(7'h0F, 1, "R9");

    // R5: clearing write accepted, reserved bits read 0
    tx_buf[0] = 8'h3F;
    wr(7'h0F, 1, -1);
    rd(7'h0F, 1, "R5");

    // R4 and R3: burst over time and alarm bytes
    for (int i = 0; i < 15; i++) tx_buf[i] = 8'h10 + 8'(i * 3);
    wr(7'h00, 15, -1);
    rd(7'h00, 15, "");

    // R8: unmapped writes ignored, read across the boundary
    for (int i = 0; i < 3; i++) tx_buf[i] = 8'hFF;
    wr(7'h12, 3, -1);
    rd(7'h0E, 7, "");

    // R3: wrap from 0x7F to 0x00
    tx_buf[0] = 8'hC1; tx_buf[1] = 8'hC2; tx_buf[2] = 8'hC3; tx_buf[3] = 8'hC4;
    wr(7'h7E, 4, -1);
    rd(7'h7E, 4, "R3");

    // R7: configuration burst
    tx_buf[0] = 8'h03; tx_buf[1] = 8'hFF; tx_buf[2] = 8'h5A;
    wr(7'h0F, 3, -1);
    rd(7'h0F, 3, "");

    // storage bytes used later
    tx_buf[0] = 8'hAB; tx_buf[1] = 8'hCD;
    wr(7'h20, 2, -1);
    rd(7'h20, 2, "R4");

    // R9: protect again, storage write ignored, then clear inside a burst
    tx_buf[0] = 8'h43;
    wr(7'h0F, 1, -1);
    tx_buf[0] = 8'h99;
    wr(7'h20, 1, -1);
    rd(7'h20, 1, "R9");
    tx_buf[0] = 8'h03; tx_buf[1] = 8'h00; tx_buf[2] = 8'h77;
    wr(7'h0F, 3, -1);
    rd(7'h0F, 3, "R9");

    // R10: timekeeping read port
    @(negedge clk);
    tk_addr = 7'h21;
    @(negedge clk);
    @(negedge clk);
    chk("R10", tk_rdata, 8'hCD);
    tk_addr = 7'h05;
    @(negedge clk);
    @(negedge clk);
    chk("R10", tk_rdata, m_mem[5]);

    // R6: flags set by alarm pulses, selective clear
    pulse_alarm(2'b11);
    @(negedge clk);
    rd(7'h10, 1, "R6");
    tx_buf[0] = 8'h02;
    wr(7'h10, 1, -1);
    rd(7'h10, 1, "R6");

    // R6: alarm pulse around the cycle of a clearing write
    for (int k = 2; k <= 4; k++) begin
      pulse_alarm(2'b01);
      tx_buf[0] = 8'h00;
      txn(8'h90, 1, k);
      m_flag = {1'b0, (k >= 3)};
      chk("R6", {6'b0, alarm_flag}, {6'b0, m_flag});
      idle_chk = 1'b1;
      rd(7'h10, 1, "R6");
    end

    // R2: abandoned partial byte, then a clean transaction
    idle_chk = 1'b0;
    @(negedge clk);
    spi_cs = 1'b1;
    repeat (8) @(negedge clk);
    for (int i = 7; i >= 4; i--) begin
      spi_sclk = 1'b1;
      spi_mosi = 1'(8'h8F >> i);
      repeat (HALF) @(negedge clk);
      spi_sclk = 1'b0;
      repeat (HALF) @(negedge clk);
    end
    spi_cs = 1'b0;
    repeat (8) @(negedge clk);
    chk("R2", {7'b0, spi_miso_oe}, 8'h00);
    idle_chk = 1'b1;
    rd(7'h0F, 1, "R2");
    rd(7'h00, 2, "R2");

    repeat (10) @(negedge clk);
    finish_run();
  end

endmodule